// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words as the clock master of a two-wire synchronous link. It drives the shift clock on `sclk_out` from a programmable divider and captures the single data line `sdata_in` on every falling edge of that clock. Words are 8 bits wide, or 9 bits when the ninth-bit option is on. Software either asks for exactly one word or lets reception run continuously. If it does both, continuous reception wins.

Each finished word enters a two-entry holding buffer. The oldest entry is always visible on the read-data outputs, and the ninth bit has its own output. A ready flag and an optional interrupt request announce that data is waiting. In continuous mode, a word that finishes while the buffer is full is thrown away and raises a sticky overrun flag, which halts the clock. The only way to clear that flag is to drop the continuous enable.

Top module: `sync_master_rx`

## Requirements
- R1: `sclk_out` toggles only when `port_en`, `sync_mode` and `clk_master` are all 1 and at least one of `cont_en` or `single_busy` is 1. In any other case it stays low and nothing is received.
- R2: While running, `sclk_out` is high for 2*(divisor+1) system clocks and then low for 2*(divisor+1) system clocks, which gives a period of 4*(divisor+1). When idle it rests low.
- R3: On each falling edge of `sclk_out` the block captures `sdata_in`. The first bit captured is data bit 0, and the rest follow in rising bit order. With `nine_bit_en`=1 the ninth bit captured appears on `rx_bit8`. With `nine_bit_en`=0, `rx_bit8` reads 0.
- R4: A one-cycle `single_req` pulse sets `single_busy`. After one word has been received, `single_busy` clears by itself and `sclk_out` stays low.
- R5: With `cont_en`=1, words are received back to back with no gap between them. If `single_busy` is also set, it clears after the first word, but reception keeps going.
- R6: A finished word appears on `rx_data`/`rx_bit8` and raises `rx_ready` one system clock after the edge on which `sclk_out` falls for the word's last bit.
- R7: The buffer holds two words in arrival order. A `rd_pop` pulse while `rx_ready`=1 removes the oldest word. `rx_ready` is 0 exactly when the buffer is empty.
- R8: With `cont_en`=1, a word that finishes while both entries are full is discarded. It also sets `rx_overrun` and holds `sclk_out` low. `rx_overrun` is held at 0 on every cycle that `cont_en` is 0.
- R9: With `cont_en`=0, a single word that finishes into a full buffer is dropped. `rx_overrun` stays 0 and the buffered words are not changed.
- R10: `rx_irq` is 1 exactly when `rx_ready` and `irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Selects synchronous operation |
| clk_master | input | 1 | Block sources the shift clock |
| nine_bit_en | input | 1 | Receive 9-bit words |
| irq_en | input | 1 | Interrupt request enable |
| divisor | input | DIV_W | Shift clock divider setting |
| single_req | input | 1 | Pulse: request one word |
| cont_en | input | 1 | Continuous reception enable |
| rd_pop | input | 1 | Pulse: consume the oldest word |
| sdata_in | input | 1 | Serial data line |
| sclk_out | output | 1 | Generated shift clock |
| single_busy | output | 1 | One-word request pending |
| rx_data | output | 8 | Oldest buffered data byte |
| rx_bit8 | output | 1 | Ninth bit of the oldest word |
| rx_ready | output | 1 | Buffer holds at least one word |
| rx_overrun | output | 1 | Word lost in continuous mode |
| rx_irq | output | 1 | Interrupt request |

## Verification
A word's result is due exactly one system clock after the edge that drops `sclk_out` for its last bit. The bench therefore waits for that falling edge and samples `rx_ready` at the next two falling system-clock edges: it expects 0 at the first and 1 at the second. Overrun is checked at the same point. The clock high time and period are measured in system-clock periods between `sclk_out` edges. Serial data is always changed just after a rising shift-clock edge, half a shift period before the design captures it. Each pop is followed by one system clock before the next sample is taken.

// File: rtl/smr_pkg.sv
package smr_pkg;
  localparam int unsigned SMR_DATA_W = 8;

  typedef logic [SMR_DATA_W:0] smr_word_t;

  // System clocks spent in each shift clock phase.
  function automatic int unsigned smr_half_cycles(input int unsigned div);
    return 2 * (div + 1);
  endfunction

  // Number of serial bits in one word.
  function automatic int unsigned smr_bits_per_word(input logic nine);
    return nine ? SMR_DATA_W + 1 : SMR_DATA_W;
  endfunction
endpackage

// File: rtl/smr_clkgen.sv
module smr_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             sclk,
  output logic             fall_evt
);
  import smr_pkg::*;

  localparam int CW = DIV_W + 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_cnt;
  logic          terminal;

  assign last_cnt = CW'(smr_half_cycles(32'(divisor)) - 1);
  assign terminal = run && (cnt >= last_cnt);
  assign fall_evt = terminal && sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (terminal) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/smr_shifter.sv
module smr_shifter (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sample_evt,
  input  logic              nine_bit,
  input  logic              sdata,
  output logic              word_done,
  output logic              word_valid,
  output smr_pkg::smr_word_t word_q
);
  import smr_pkg::*;

  localparam int BW = $clog2(SMR_DATA_W + 1);

  logic [BW-1:0] bitcnt;
  logic          last_bit;

  assign last_bit  = (bitcnt == BW'(smr_bits_per_word(nine_bit) - 1));
  assign word_done = sample_evt && last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitcnt     <= '0;
      word_q     <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= word_done;
      if (!run) begin
        bitcnt <= '0;
      end else if (sample_evt) begin
        if (bitcnt == '0) word_q <= smr_word_t'(sdata);
        else              word_q[bitcnt] <= sdata;
        bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smr_fifo.sv
module smr_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [FW-1:0] fill,
  output logic          empty,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, do_pop, accept;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (fill == '0);
  assign full   = (fill == FW'(DEPTH));
  assign do_pop = pop && !empty;
  assign accept = push && (!full || do_pop);
  assign drop   = push && !accept;
  assign dout   = mem[rptr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (accept && (wptr == AW'(g))) mem[g] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (accept) wptr <= next_ptr(wptr);
      if (do_pop) rptr <= next_ptr(rptr);
      case ({accept, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx #(
  parameter int DIV_W = 8,
  parameter int DEPTH = 2,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             sync_mode,
  input  logic             clk_master,
  input  logic             nine_bit_en,
  input  logic             irq_en,
  input  logic [DIV_W-1:0] divisor,
  input  logic             single_req,
  input  logic             cont_en,
  input  logic             rd_pop,
  input  logic             sdata_in,
  output logic             sclk_out,
  output logic             single_busy,
  output logic [7:0]       rx_data,
  output logic             rx_bit8,
  output logic             rx_ready,
  output logic             rx_overrun,
  output logic             rx_irq
);
  import smr_pkg::*;

  logic       active, run;
  logic       sample_evt, word_done, word_valid;
  smr_word_t  word_q, head;
  logic [FW-1:0] fill;
  logic       fifo_empty, push_drop;

  assign active = port_en && sync_mode && clk_master && (cont_en || single_busy);
  assign run    = active && !rx_overrun;

  smr_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .divisor(divisor),
    .sclk(sclk_out), .fall_evt(sample_evt)
  );

  smr_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .run(run), .sample_evt(sample_evt),
    .nine_bit(nine_bit_en), .sdata(sdata_in),
    .word_done(word_done), .word_valid(word_valid), .word_q(word_q)
  );

  smr_fifo #(.W(SMR_DATA_W + 1), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(word_valid), .pop(rd_pop),
    .din(word_q), .dout(head), .fill(fill), .empty(fifo_empty),
    .drop(push_drop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         single_busy <= 1'b0;
    else if (word_done) single_busy <= 1'b0;
    else if (single_req) single_busy <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rx_overrun <= 1'b0;
    else if (!cont_en) rx_overrun <= 1'b0;
    else if (push_drop) rx_overrun <= 1'b1;
  end

  assign rx_data  = head[SMR_DATA_W-1:0];
  assign rx_bit8  = head[SMR_DATA_W];
  assign rx_ready = !fifo_empty;
  assign rx_irq   = rx_ready && irq_en;
endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
  parameter int DEPTH = 2,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_en,
  input logic          sync_mode,
  input logic          clk_master,
  input logic          cont_en,
  input logic          single_busy,
  input logic          sclk_out,
  input logic          rx_overrun,
  input logic          rx_ready,
  input logic          rx_irq,
  input logic          rd_pop,
  input logic [FW-1:0] fill,
  input logic          word_done,
  input logic          sample_evt
);
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && sync_mode && clk_master) |=> !sclk_out);

  assert_sample_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> !sclk_out);

  assert_single_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(single_busy) |-> $past(word_done));

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

  assert_ready_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(rd_pop));

  assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_en |=> !rx_overrun);

  assert_ovr_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> !sclk_out);

  assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(fill) == FW'(DEPTH));

  assert_irq_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_ready);
endmodule

bind sync_master_rx smr_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
  .clk_master(clk_master), .cont_en(cont_en), .single_busy(single_busy),
  .sclk_out(sclk_out), .rx_overrun(rx_overrun), .rx_ready(rx_ready),
  .rx_irq(rx_irq), .rd_pop(rd_pop), .fill(fill), .word_done(word_done),
  .sample_evt(sample_evt)
);

// File: tb/tb_sync_master_rx.sv
`timescale 1ns/1ps
module tb_sync_master_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b1, sync_mode = 1'b1, clk_master = 1'b1;
  logic       nine_bit_en = 1'b0, irq_en = 1'b0;
  logic [7:0] divisor = 8'd0;
  logic       single_req = 1'b0, cont_en = 1'b0, rd_pop = 1'b0, sdata = 1'b0;
  logic       sclk_out, single_busy, rx_bit8, rx_ready, rx_overrun, rx_irq;
  logic [7:0] rx_data;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sync_master_rx #(.DIV_W(8), .DEPTH(2)) dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
    .clk_master(clk_master), .nine_bit_en(nine_bit_en), .irq_en(irq_en),
    .divisor(divisor), .single_req(single_req), .cont_en(cont_en),
    .rd_pop(rd_pop), .sdata_in(sdata), .sclk_out(sclk_out),
    .single_busy(single_busy), .rx_data(rx_data), .rx_bit8(rx_bit8),
    .rx_ready(rx_ready), .rx_overrun(rx_overrun), .rx_irq(rx_irq)
  );

  function automatic int exp_word(input logic [8:0] w, input logic nine);
    return nine ? int'(w) : int'(w[7:0]);
  endfunction
  function automatic int exp_half(input int div);
    return 2 * (div + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pop_word();
    rd_pop = 1'b1; tick(); rd_pop = 1'b0;
  endtask

  task automatic ask_single();
    single_req = 1'b1; tick(); single_req = 1'b0;
  endtask

  task automatic send_bits(input logic [8:0] w, input int nb);
    for (int i = 0; i < nb; i++) begin
      @(posedge sclk_out);
      #1 sdata = w[i];
    end
  endtask

  task automatic wait_ready();
    while (!rx_ready) tick();
  endtask

  function automatic int got();
    return int'({rx_bit8, rx_data});
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    longint t0, t1, t2;
    int highs;
    logic [8:0] w;
    logic [8:0] ws [4];
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset sclk", int'(sclk_out), 0);
    chk("R7 reset ready", int'(rx_ready), 0);
    chk("R8 reset overrun", int'(rx_overrun), 0);

    // Directed: single 8-bit word, clock timing and result latency
    divisor = 8'd2; nine_bit_en = 1'b0; w = 9'h1A5;
    ask_single();
    chk("R4 single set", int'(single_busy), 1);
    fork
      send_bits(w, 8);
      begin
        @(posedge sclk_out); t0 = $time;
        @(negedge sclk_out); t1 = $time;
        @(posedge sclk_out); t2 = $time;
      end
    join
    chk("R2 high time", int'((t1 - t0) / 8), exp_half(2));
    chk("R2 period", int'((t2 - t0) / 8), 2 * exp_half(2));
    @(negedge sclk_out);
    tick();
    chk("R6 ready not yet", int'(rx_ready), 0);
    tick();
    chk("R6 ready due", int'(rx_ready), 1);
    chk("R3 lsb-first data", got(), exp_word(w, 1'b0));
    chk("R4 single cleared", int'(single_busy), 0);
    highs = 0;
    repeat (20) begin tick(); if (sclk_out) highs++; end
    chk("R4 clock stopped", highs, 0);
    pop_word();
    chk("R7 empty after pop", int'(rx_ready), 0);

    // Directed: 9-bit word at the fastest divisor
    divisor = 8'd0; nine_bit_en = 1'b1; w = 9'h13C;
    ask_single();
    send_bits(w, 9);
    wait_ready();
    chk("R3 ninth bit word", got(), exp_word(w, 1'b1));
    pop_word();

    // Random single words
    for (int k = 0; k < 8; k++) begin
      divisor = 8'($urandom_range(0, 3));
      nine_bit_en = 1'($urandom_range(0, 1));
      w = 9'($urandom);
      ask_single();
      send_bits(w, nine_bit_en ? 9 : 8);
      wait_ready();
      chk("R3 random word", got(), exp_word(w, nine_bit_en));
      pop_word();
    end

    // Continuous reception with reads and interrupts
    divisor = 8'd1; nine_bit_en = 1'b0; irq_en = 1'b1;
    for (int k = 0; k < 4; k++) ws[k] = 9'($urandom);
    cont_en = 1'b1;
    fork
      for (int k = 0; k < 4; k++) send_bits(ws[k], 8);
      for (int k = 0; k < 4; k++) begin
        wait_ready();
        chk("R5 continuous word", got(), exp_word(ws[k], 1'b0));
        if (k == 0) chk("R10 irq with ready", int'(rx_irq), 1);
        pop_word();
        if (k == 3) cont_en = 1'b0;
      end
    join
    tick();
    chk("R10 irq idle", int'(rx_irq), 0);
    irq_en = 1'b0;

    // Overrun in continuous mode
    divisor = 8'd0;
    for (int k = 0; k < 3; k++) ws[k] = 9'($urandom);
    cont_en = 1'b1;
    for (int k = 0; k < 3; k++) send_bits(ws[k], 8);
    @(negedge sclk_out);
    tick(); tick();
    chk("R8 overrun set", int'(rx_overrun), 1);
    highs = 0;
    repeat (30) begin tick(); if (sclk_out) highs++; end
    chk("R8 clock halted", highs, 0);
    chk("R8 overrun sticky", int'(rx_overrun), 1);
    cont_en = 1'b0;
    tick();
    chk("R8 overrun cleared", int'(rx_overrun), 0);
    chk("R7 oldest first", got(), exp_word(ws[0], 1'b0));
    pop_word();
    chk("R7 second word", got(), exp_word(ws[1], 1'b0));
    pop_word();
    chk("R8 third dropped", int'(rx_ready), 0);

    // Single word into a full buffer
    for (int k = 0; k < 3; k++) begin
      ws[k] = 9'($urandom);
      ask_single();
      send_bits(ws[k], 8);
      while (single_busy) tick();
      tick(); tick();
    end
    chk("R9 no overrun", int'(rx_overrun), 0);
    chk("R9 keep first", got(), exp_word(ws[0], 1'b0));
    pop_word();
    chk("R9 keep second", got(), exp_word(ws[1], 1'b0));
    pop_word();
    chk("R9 third dropped", int'(rx_ready), 0);

    // Both enables: continuous wins
    divisor = 8'd1;
    ws[0] = 9'h05A; ws[1] = 9'h0C3;
    cont_en = 1'b1;
    ask_single();
    fork
      for (int k = 0; k < 2; k++) send_bits(ws[k], 8);
      begin
        wait_ready();
        chk("R5 single flag cleared", int'(single_busy), 0);
        chk("R5 first word", got(), exp_word(ws[0], 1'b0));
        pop_word();
        wait_ready();
        chk("R5 continues", got(), exp_word(ws[1], 1'b0));
        pop_word();
        cont_en = 1'b0;
      end
    join

    // Gating by each configuration bit
    for (int c = 0; c < 3; c++) begin
      port_en = (c != 0); sync_mode = (c != 1); clk_master = (c != 2);
      cont_en = 1'b1;
      highs = 0;
      repeat (40) begin tick(); if (sclk_out) highs++; end
      chk("R1 gated clock", highs, 0);
      chk("R1 gated data", int'(rx_ready), 0);
      cont_en = 1'b0;
      tick();
    end
    port_en = 1'b1; sync_mode = 1'b1; clk_master = 1'b1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule